// File: doc/BRIEF.md
# Multi-Device EPROM Read Controller

This block sits between a system bus and a bank of byte-wide asynchronous read-only memory devices that all drive one shared data bus. A read request carries a wide byte address. The upper address bits choose a device, and the lower bits go out on a common address bus. Each device has its own active-low chip enable, which acts as both its select and its power control. A single active-low output enable is shared by every device and gates its data drivers.

The controller counts clock cycles to cover three access paths: address to data, chip enable to data, and output enable to data. It delays the output enable so that it is asserted no earlier than it needs to be. It samples the bus once the slowest of the three paths has completed, returns the byte with a one-cycle valid pulse and then releases the output enable. The last device read stays selected, so a further read to it does not need a turnaround. Before a different device is enabled, every chip enable is held high for a programmable float time, which lets the previous device's drivers turn off. An address above the populated devices enables nothing and is answered at once with an error.

Top module: `eprom_rd_ctrl`

## Requirements
- R1: After reset every chip enable and the output enable are high, no response is pending and the request port is ready.
- R2: A read selects device `req_addr[ADDR_W-1:DEV_AW]` by driving that device's chip enable low, and drives `req_addr[DEV_AW-1:0]` onto `mem_addr`. After the response, that device remains the only one selected.
- R3: At most one chip enable is low in any cycle, and the output enable is low only while exactly one chip enable is low.
- R4: The returned byte is the value the selected device presents once the address and chip enable have both been stable for the access-time waits and the output enable has been low for its own wait.
- R5: A read to the device that is already selected, or the first read after reset, responds SAMPLE cycles after the request is accepted. SAMPLE is max(T_ADDR, T_CE, OE_START + T_OE), and OE_START is max(0, max(T_ADDR, T_CE) − T_OE).
- R6: The output enable is high in the cycle that carries the response.
- R7: A read to a device other than the last one read keeps every chip enable high for T_FLOAT cycles and then responds T_FLOAT + SAMPLE cycles after acceptance.
- R8: A request whose device index is NUM_DEV or above drives all chip enables high, returns `rsp_err` = 1 with `rsp_data` = 0 in the cycle after acceptance, and is not counted as a device switch for a later read to the last device.
- R9: `req_ready` is low from acceptance until the response, and `rsp_valid` is a single-cycle pulse for each accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request, taken when `req_ready` is high |
| req_addr | input | ADDR_W | Byte address: device index above bit DEV_AW, offset below it |
| req_ready | output | 1 | Controller idle and able to accept a request |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_err | output | 1 | Response is for an unpopulated address |
| rsp_data | output | DATA_W | Byte read from the device (zero on error) |
| mem_addr | output | DEV_AW | Address bus shared by all devices |
| mem_ce_n | output | NUM_DEV | Active-low chip enable, one per device |
| mem_oe_n | output | 1 | Active-low output enable, shared by all devices |
| mem_dq | input | DATA_W | Shared device data bus |

## Verification
A wrong wait count or a wrong sampling point returns a byte that the device model has not yet made valid, so the corrupted value appears in the very response where the fault occurs. A wrong state or wrong selection shows in the same clock cycle as a second low chip enable or as an output enable with no device selected. It can also show as a device switch with fewer than T_FLOAT idle cycles, which is seen at the moment the new chip enable falls. Response latency is measured from the port side for every read, so a missing or extra cycle anywhere in the sequence is reported on the read that contains it.

// File: rtl/eprom_rd_pkg.sv
`timescale 1ns/1ps
package eprom_rd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FLOAT  = 2'd1,
    ST_ACCESS = 2'd2
  } rd_state_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/eprom_wait_timer.sv
`timescale 1ns/1ps
module eprom_wait_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  output logic [CW-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (cnt != {CW{1'b1}}) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/eprom_ce_decode.sv
`timescale 1ns/1ps
module eprom_ce_decode #(
  parameter int NUM_DEV = 3,
  parameter int SEL_W   = 2
) (
  input  logic               en,
  input  logic [SEL_W-1:0]   sel,
  output logic [NUM_DEV-1:0] ce_n
);
  for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
    assign ce_n[d] = !(en && (sel == SEL_W'(d)));
  end
endmodule

// File: rtl/eprom_rd_ctrl.sv
`timescale 1ns/1ps
module eprom_rd_ctrl
  import eprom_rd_pkg::*;
#(
  parameter int ADDR_W  = 10,
  parameter int DEV_AW  = 8,
  parameter int NUM_DEV = 3,
  parameter int DATA_W  = 8,
  parameter int T_ADDR  = 4,
  parameter int T_CE    = 4,
  parameter int T_OE    = 2,
  parameter int T_FLOAT = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [ADDR_W-1:0]  req_addr,
  output logic               req_ready,
  output logic               rsp_valid,
  output logic               rsp_err,
  output logic [DATA_W-1:0]  rsp_data,
  output logic [DEV_AW-1:0]  mem_addr,
  output logic [NUM_DEV-1:0] mem_ce_n,
  output logic               mem_oe_n,
  input  logic [DATA_W-1:0]  mem_dq
);
  localparam int SEL_W    = ADDR_W - DEV_AW;
  localparam int T_SLOW   = imax(T_ADDR, T_CE);
  localparam int OE_START = (T_SLOW > T_OE) ? (T_SLOW - T_OE) : 0;
  localparam int SAMPLE   = imax(T_SLOW, OE_START + T_OE);
  localparam int CW       = $clog2(imax(SAMPLE, T_FLOAT) + 2);
  localparam logic [CW-1:0] SAMPLE_LAST = CW'(SAMPLE - 1);
  localparam logic [CW-1:0] FLOAT_LAST  = CW'((T_FLOAT > 0) ? T_FLOAT - 1 : 0);
  localparam logic [CW-1:0] OE_LAST     = CW'((OE_START > 0) ? OE_START - 1 : 0);
  localparam bit OE_AT_START = (OE_START == 0);
  localparam bit USE_FLOAT   = (T_FLOAT > 0);

  rd_state_e          state_q, state_d;
  logic [CW-1:0]      cnt;
  logic               tmr_clr;
  logic               on_q, on_d;
  logic [SEL_W-1:0]   sel_q, sel_d, last_sel_q;
  logic               last_vld_q;
  logic               oe_d, rsp_fire, err_fire;
  logic [NUM_DEV-1:0] ce_n_d;
  logic [SEL_W-1:0]   req_sel;
  logic               req_in_rng;

  assign req_sel    = req_addr[ADDR_W-1 -: SEL_W];
  assign req_in_rng = ({1'b0, req_sel} < (SEL_W+1)'(NUM_DEV));
  assign req_ready  = (state_q == ST_IDLE);

  eprom_wait_timer #(.CW(CW)) u_tmr (
    .clk (clk),
    .rst (rst),
    .clr (tmr_clr),
    .cnt (cnt)
  );

  eprom_ce_decode #(.NUM_DEV(NUM_DEV), .SEL_W(SEL_W)) u_dec (
    .en   (on_d),
    .sel  (sel_d),
    .ce_n (ce_n_d)
  );

  always_comb begin
    state_d  = state_q;
    on_d     = on_q;
    sel_d    = sel_q;
    oe_d     = 1'b0;
    tmr_clr  = 1'b0;
    rsp_fire = 1'b0;
    err_fire = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          if (!req_in_rng) begin
            on_d     = 1'b0;
            err_fire = 1'b1;
          end else begin
            sel_d   = req_sel;
            tmr_clr = 1'b1;
            if (USE_FLOAT && last_vld_q && (req_sel != last_sel_q)) begin
              on_d    = 1'b0;
              state_d = ST_FLOAT;
            end else begin
              on_d    = 1'b1;
              oe_d    = OE_AT_START;
              state_d = ST_ACCESS;
            end
          end
        end
      end
      ST_FLOAT: begin
        if (cnt == FLOAT_LAST) begin
          on_d    = 1'b1;
          tmr_clr = 1'b1;
          oe_d    = OE_AT_START;
          state_d = ST_ACCESS;
        end
      end
      ST_ACCESS: begin
        if (cnt == SAMPLE_LAST) begin
          rsp_fire = 1'b1;
          state_d  = ST_IDLE;
        end else begin
          oe_d = OE_AT_START || (cnt >= OE_LAST);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      on_q       <= 1'b0;
      sel_q      <= '0;
      last_sel_q <= '0;
      last_vld_q <= 1'b0;
      mem_ce_n   <= '1;
      mem_oe_n   <= 1'b1;
      mem_addr   <= '0;
      rsp_valid  <= 1'b0;
      rsp_err    <= 1'b0;
      rsp_data   <= '0;
    end else begin
      state_q   <= state_d;
      on_q      <= on_d;
      sel_q     <= sel_d;
      mem_ce_n  <= ce_n_d;
      mem_oe_n  <= !oe_d;
      rsp_valid <= rsp_fire || err_fire;
      rsp_err   <= err_fire;
      if (req_valid && req_ready && req_in_rng) mem_addr <= req_addr[DEV_AW-1:0];
      if (rsp_fire) begin
        rsp_data   <= mem_dq;
        last_vld_q <= 1'b1;
        last_sel_q <= sel_q;
      end else if (err_fire) begin
        rsp_data <= '0;
      end
    end
  end
endmodule

// File: rtl/eprom_rd_ctrl_chk.sv
`timescale 1ns/1ps
module eprom_rd_ctrl_chk #(
  parameter int ADDR_W  = 10,
  parameter int DEV_AW  = 8,
  parameter int NUM_DEV = 3
) (
  input logic               clk,
  input logic               rst,
  input logic               req_valid,
  input logic               req_ready,
  input logic [ADDR_W-1:0]  req_addr,
  input logic               rsp_valid,
  input logic               rsp_err,
  input logic [NUM_DEV-1:0] mem_ce_n,
  input logic               mem_oe_n
);
  localparam int SEL_W = ADDR_W - DEV_AW;
  logic out_of_rng;
  assign out_of_rng = ({1'b0, req_addr[ADDR_W-1 -: SEL_W]} >= (SEL_W+1)'(NUM_DEV));

  assert_single_ce_R3: assert property (@(posedge clk) disable iff (rst)
    $countones(~mem_ce_n) <= 1);

  assert_oe_needs_ce_R3: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> ($countones(~mem_ce_n) == 1));

  assert_oe_off_at_rsp_R6: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> mem_oe_n);

  assert_err_reply_R8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && out_of_rng) |=> (rsp_valid && rsp_err && (&mem_ce_n)));

  assert_rsp_when_idle_R9: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> req_ready);
endmodule

bind eprom_rd_ctrl eprom_rd_ctrl_chk #(
  .ADDR_W(ADDR_W), .DEV_AW(DEV_AW), .NUM_DEV(NUM_DEV)
) chk_i (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
  .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n)
);

// File: tb/eprom_rd_ctrl_tb_top.sv
`timescale 1ns/1ps
module eprom_rd_ctrl_tb_top;
  localparam int ADDR_W = 10, DEV_AW = 8, NUM_DEV = 3, DATA_W = 8;
  localparam int T_ADDR = 4, T_CE = 4, T_OE = 2, T_FLOAT = 2;
  localparam int SAMPLE = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic               req_valid = 1'b0;
  logic [ADDR_W-1:0]  req_addr  = '0;
  logic               req_ready, rsp_valid, rsp_err, mem_oe_n;
  logic [DATA_W-1:0]  rsp_data;
  logic [DEV_AW-1:0]  mem_addr;
  logic [NUM_DEV-1:0] mem_ce_n;
  logic [DATA_W-1:0]  dq_m = 8'hEE;

  eprom_rd_ctrl #(
    .ADDR_W(ADDR_W), .DEV_AW(DEV_AW), .NUM_DEV(NUM_DEV), .DATA_W(DATA_W),
    .T_ADDR(T_ADDR), .T_CE(T_CE), .T_OE(T_OE), .T_FLOAT(T_FLOAT)
  ) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
    .rsp_data(rsp_data), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
    .mem_oe_n(mem_oe_n), .mem_dq(dq_m)
  );

  int n_run  = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int dev, input int off);
    return 8'((off * 3 + dev * 64 + 1) % 256);
  endfunction

  function automatic int low_idx(input logic [NUM_DEV-1:0] c);
    for (int i = 0; i < NUM_DEV; i++) if (!c[i]) return i;
    return -1;
  endfunction

  // Device bank model: drives real data only when the timing waits are met
  logic [DEV_AW-1:0]  pa = '0;
  logic [NUM_DEV-1:0] pce = '1;
  logic               poe = 1'b1;
  int acnt = 0, ccnt = 0, ocnt = 0;
  int idle_run = 100, last_dev = -1;
  bit contention = 1'b0, float_bad = 1'b0;
  int switches = 0;

  always @(negedge clk) begin
    acnt = (mem_addr == pa) ? acnt + 1 : 0;
    ccnt = (mem_ce_n == pce) ? ccnt + 1 : 0;
    ocnt = (!mem_oe_n && !poe) ? ocnt + 1 : 0;
    if (!rst && $countones(~mem_ce_n) > 1) contention = 1'b1;
    if (!rst && !mem_oe_n && (&mem_ce_n)) contention = 1'b1;
    if (&mem_ce_n) idle_run++;
    else begin
      if ((&pce) && last_dev >= 0 && low_idx(mem_ce_n) != last_dev) begin
        switches++;
        if (idle_run < T_FLOAT) float_bad = 1'b1;
      end
      last_dev = low_idx(mem_ce_n);
      idle_run = 0;
    end
    if ($countones(~mem_ce_n) == 1 && !mem_oe_n && acnt >= T_ADDR - 1 &&
        ccnt >= T_CE - 1 && ocnt >= T_OE - 1)
      dq_m = pat(low_idx(mem_ce_n), int'(mem_addr));
    else
      dq_m = 8'hEE;
    pa = mem_addr; pce = mem_ce_n; poe = mem_oe_n;
  end

  // One read scenario; starts and ends at a falling edge
  task automatic do_read(input logic [ADDR_W-1:0] a, input bit exp_err,
                         input int exp_lat, input string rq);
    int lat = 0;
    bit busy_ok = 1'b1;
    int dev = int'(a[ADDR_W-1:DEV_AW]);
    int off = int'(a[DEV_AW-1:0]);
    req_valid = 1'b1; req_addr = a;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid && lat < 40) begin
      if (req_ready) busy_ok = 1'b0;
      @(posedge clk); @(negedge clk);
      lat++;
    end
    chk(lat == exp_lat, rq, "latency", lat, exp_lat);
    chk(busy_ok, "R9", "ready low while busy", int'(busy_ok), 1);
    chk(rsp_err == exp_err, exp_err ? "R8" : rq, "error flag", int'(rsp_err), int'(exp_err));
    if (exp_err) begin
      chk(rsp_data == 8'h00, "R8", "error data", int'(rsp_data), 0);
      chk(&mem_ce_n, "R8", "no chip enable", int'(mem_ce_n), 7);
    end else begin
      chk(rsp_data == pat(dev, off), "R4", "read data", int'(rsp_data), int'(pat(dev, off)));
      chk(mem_ce_n == ~(NUM_DEV'(1) << dev), "R2", "chip enable", int'(mem_ce_n),
          int'(~(NUM_DEV'(1) << dev)));
      chk(int'(mem_addr) == off, "R2", "device address", int'(mem_addr), off);
    end
    chk(mem_oe_n, "R6", "oe high at response", int'(mem_oe_n), 1);
    @(posedge clk); @(negedge clk);
    chk(!rsp_valid, "R9", "single-cycle pulse", int'(rsp_valid), 0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    chk(&mem_ce_n, "R1", "ce after reset", int'(mem_ce_n), 7);
    chk(mem_oe_n && !rsp_valid && req_ready, "R1", "oe/rsp/ready after reset",
        int'({mem_oe_n, rsp_valid, req_ready}), 5);
  endtask

  task automatic t_same_dev();
    do_read(10'h012, 1'b0, SAMPLE, "R5");
    do_read(10'h0FF, 1'b0, SAMPLE, "R5");
  endtask

  task automatic t_switch();
    do_read(10'h134, 1'b0, T_FLOAT + SAMPLE, "R7");
    do_read(10'h2AB, 1'b0, T_FLOAT + SAMPLE, "R7");
    do_read(10'h200, 1'b0, SAMPLE, "R5");
  endtask

  task automatic t_out_of_range();
    do_read(10'h3C0, 1'b1, 0, "R8");
    do_read(10'h201, 1'b0, SAMPLE, "R8");
    do_read(10'h040, 1'b0, T_FLOAT + SAMPLE, "R7");
  endtask

  task automatic t_monitors();
    chk(!contention, "R3", "bus contention seen", int'(contention), 0);
    chk(!float_bad, "R7", "short float gap", int'(float_bad), 0);
    chk(switches == 3, "R7", "device switches seen", switches, 3);
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    t_reset();
    t_same_dev();
    t_switch();
    t_out_of_range();
    t_monitors();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule